// File: doc/BRIEF.md
# PSE-Type Classification Flag Unit

This block sits in the digital part of a powered-device front end. Comparators on the port voltage produce two window signals: one says the voltage is in the class-current window, the other says it is in the mark window (roughly 4.9 V to 10.1 V). During multi-event classification the block counts class fingers. Each time the voltage drops from the class window into the mark window, the count goes up by one. The count, together with two pair-sense inputs, tells the block which kind of power source is attached: a type-2 source, an HDBaseT source, or a four-pair version of either.

Once soft start finishes, a settling timer runs for `DELAY_CYC` cycles (the default is 80 ms at 50 MHz). When the timer expires, the decoded flags are captured and then frozen. Each flag output is active low. A 0 means the open-drain pin is pulled low (asserted), and a 1 means the pin is high impedance. A wall-adapter enable input forces all four flags low.

The control machine has three states:
- CLASSIFY counts fingers while the isolation switch is off.
- SETTLE runs the timer and is entered when `ss_done` is seen in CLASSIFY.
- LATCHED drives the captured flags and is entered when the timer expires.

Two conditions send any state back to CLASSIFY. `iso_off` does so and keeps the count. `port_lo` does so and also clears all class state.

Top module: `pse_class_flags`

## Requirements
- R1: A finger is counted only in CLASSIFY, when `mark_win` is high, `cls_win` is low, and the last window seen was the class window. Mark windows with no class window before them, and any window activity outside CLASSIFY, add nothing.
- R2: The finger count saturates at `MAX_FINGERS` (7). A count of 7 or more decodes to no flags, so 8 or 10 fingers give all flags released.
- R3: The count decodes as follows, with t2 the lowest-power flag:
  - 0 or 1 fingers: none.
  - 2 fingers: t2.
  - 3 fingers: t2 and hd.
  - 4 fingers: t2, hd and quad_t2.
  - 5 fingers (reserved): none.
  - 6 fingers: all four flags.
- R4: When both `sense_a` and `sense_b` are high at capture, a count of 2 or 3 also asserts quad_t2. A single high sense input changes nothing.
- R5: After `ss_done` is sampled in CLASSIFY, the flags stay released for `DELAY_CYC`-1 clock edges and assert after edge `DELAY_CYC`.
- R6: In LATCHED, changes on the sense inputs do not change the flags.
- R7: `iso_off` releases all flags after the next edge and keeps the count, so a later `ss_done` decodes the same count again.
- R8: `port_lo` releases all flags after the next edge and clears the count to 0.
- R9: While `wa_en` is high, all four flag outputs are 0 (asserted) in every state, with no clock delay. When `wa_en` drops, the outputs return to what the state machine drives.
- R10: An asserted flag implies that every lower-power flag is asserted: hd implies t2, quad_t2 implies t2, and quad_hd implies all others.
- R11: After reset, the state is CLASSIFY, the count is 0 and all flags are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_win | input | 1 | Port voltage is in the class-current window |
| mark_win | input | 1 | Port voltage is in the mark window |
| port_lo | input | 1 | Port voltage is below the class-reset level; clears class state |
| iso_off | input | 1 | Port voltage is below the isolation-switch turn-off level |
| ss_done | input | 1 | Soft start has completed |
| sense_a | input | 1 | First pair-sense input is active |
| sense_b | input | 1 | Second pair-sense input is active |
| wa_en | input | 1 | Wall-adapter enable; forces all flags asserted |
| t2_n | output | 1 | Type-2 flag, 0 = asserted |
| hd_n | output | 1 | HDBaseT flag, 0 = asserted |
| quad_t2_n | output | 1 | Four-pair type-2 flag, 0 = asserted |
| quad_hd_n | output | 1 | Four-pair HDBaseT flag, 0 = asserted |

## Verification
The results fall due at different times:
- Finger counting has no visible output of its own, so it is observed through the flags after a full power-up.
- The flags stay released after edge `DELAY_CYC`-1 following the edge that samples `ss_done`, and are due exactly after edge `DELAY_CYC`.
- Releases caused by `iso_off` and `port_lo` are due after the one edge that samples them.
- The `wa_en` override is combinational and is checked 1 ns after it is driven.

The bench drives inputs on falling edges and counts falling edges from the sampling edge, so each check lands in the cycle where its result first becomes due.

// File: rtl/pse_cls_pkg.sv
`timescale 1ns/1ps
package pse_cls_pkg;

    typedef enum logic [1:0] {
        ST_CLASSIFY = 2'd0,
        ST_SETTLE   = 2'd1,
        ST_LATCHED  = 2'd2
    } fsm_t;

    // Active-high view of the four type flags, lowest power in bit 0.
    typedef struct packed {
        logic quad_hd;
        logic quad_t2;
        logic hd;
        logic t2;
    } flag_set_t;

endpackage

// File: rtl/pse_finger_cnt.sv
`timescale 1ns/1ps
module pse_finger_cnt #(
    parameter int MAX_FINGERS = 7,
    localparam int CW = $clog2(MAX_FINGERS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          enable,
    input  logic          cls_win,
    input  logic          mark_win,
    output logic [CW-1:0] count
);
    logic seen_cls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_cls <= 1'b0;
            count    <= '0;
        end else if (clr) begin
            seen_cls <= 1'b0;
            count    <= '0;
        end else if (enable) begin
            if (cls_win) begin
                seen_cls <= 1'b1;
            end else if (mark_win) begin
                seen_cls <= 1'b0;
                if (seen_cls && count != CW'(MAX_FINGERS))
                    count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pse_settle_timer.sv
`timescale 1ns/1ps
module pse_settle_timer #(
    parameter int DELAY_CYC = 4_000_000,
    localparam int TW = $clog2(DELAY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    logic [TW-1:0] elapsed;

    assign expire = run && (elapsed == TW'(DELAY_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            elapsed <= '0;
        else if (!run)
            elapsed <= '0;
        else if (!expire)
            elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/pse_flag_decode.sv
`timescale 1ns/1ps
module pse_flag_decode
    import pse_cls_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [CW-1:0] count,
    input  logic          sense_a,
    input  logic          sense_b,
    output flag_set_t     flags
);
    logic both_pairs;
    assign both_pairs = sense_a & sense_b;

    always_comb begin
        flags = '0;
        case (count)
            CW'(2): begin
                flags.t2      = 1'b1;
                flags.quad_t2 = both_pairs;
            end
            CW'(3): begin
                flags.t2      = 1'b1;
                flags.hd      = 1'b1;
                flags.quad_t2 = both_pairs;
            end
            CW'(4): begin
                flags.t2      = 1'b1;
                flags.hd      = 1'b1;
                flags.quad_t2 = 1'b1;
            end
            CW'(6): flags = '1;
            default: flags = '0;
        endcase
    end
endmodule

// File: rtl/pse_class_flags.sv
`timescale 1ns/1ps
module pse_class_flags
    import pse_cls_pkg::*;
#(
    parameter int DELAY_CYC   = 4_000_000,
    parameter int MAX_FINGERS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cls_win,
    input  logic mark_win,
    input  logic port_lo,
    input  logic iso_off,
    input  logic ss_done,
    input  logic sense_a,
    input  logic sense_b,
    input  logic wa_en,
    output logic t2_n,
    output logic hd_n,
    output logic quad_t2_n,
    output logic quad_hd_n
);
    localparam int CW = $clog2(MAX_FINGERS + 1);

    fsm_t          state, state_nxt;
    logic [CW-1:0] finger_cnt;
    logic          timer_expire;
    logic          is_latched;
    flag_set_t     decoded, captured;

    pse_finger_cnt #(.MAX_FINGERS(MAX_FINGERS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (port_lo),
        .enable   (state == ST_CLASSIFY),
        .cls_win  (cls_win),
        .mark_win (mark_win),
        .count    (finger_cnt)
    );

    pse_settle_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_SETTLE),
        .expire (timer_expire)
    );

    pse_flag_decode #(.CW(CW)) u_dec (
        .count   (finger_cnt),
        .sense_a (sense_a),
        .sense_b (sense_b),
        .flags   (decoded)
    );

    // Next-state logic; port_lo and iso_off override every transition.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_CLASSIFY: if (ss_done)      state_nxt = ST_SETTLE;
            ST_SETTLE:   if (timer_expire) state_nxt = ST_LATCHED;
            ST_LATCHED:  state_nxt = ST_LATCHED;
            default:     state_nxt = ST_CLASSIFY;
        endcase
        if (iso_off || port_lo)
            state_nxt = ST_CLASSIFY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_CLASSIFY;
        else
            state <= state_nxt;
    end

    // Decoded flags are frozen on the edge that enters LATCHED.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            captured <= '0;
        else if (state == ST_SETTLE && state_nxt == ST_LATCHED)
            captured <= decoded;
    end

    assign is_latched = (state == ST_LATCHED);

    // Output process: a 0 pulls the open-drain pin low.
    always_comb begin
        if (wa_en)
            {quad_hd_n, quad_t2_n, hd_n, t2_n} = 4'b0000;
        else if (is_latched)
            {quad_hd_n, quad_t2_n, hd_n, t2_n} = ~captured;
        else
            {quad_hd_n, quad_t2_n, hd_n, t2_n} = 4'b1111;
    end
endmodule

// File: rtl/pse_class_flags_chk.sv
`timescale 1ns/1ps
module pse_class_flags_chk #(
    parameter int MAX_FINGERS = 7,
    localparam int CW = $clog2(MAX_FINGERS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          port_lo,
    input logic          iso_off,
    input logic          wa_en,
    input logic          t2_n,
    input logic          hd_n,
    input logic          quad_t2_n,
    input logic          quad_hd_n,
    input logic          latched,
    input logic [CW-1:0] count
);
    logic [3:0] pins;
    assign pins = {quad_hd_n, quad_t2_n, hd_n, t2_n};

    p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(MAX_FINGERS) && !port_lo) |=> count == CW'(MAX_FINGERS));

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wa_en && $past(!wa_en) && $past(latched) && $past(!iso_off) && $past(!port_lo))
        |-> $stable(pins));

    p_iso_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iso_off |=> (wa_en || pins == 4'b1111));

    p_lo_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        port_lo |=> count == '0);

    p_adapter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wa_en |-> pins == 4'b0000);

    p_hd_needs_t2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_n |-> !t2_n);

    p_qt2_needs_t2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_t2_n |-> !t2_n);

    p_qhd_needs_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_hd_n |-> (!quad_t2_n && !hd_n && !t2_n));
endmodule

bind pse_class_flags pse_class_flags_chk #(.MAX_FINGERS(MAX_FINGERS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_lo   (port_lo),
    .iso_off   (iso_off),
    .wa_en     (wa_en),
    .t2_n      (t2_n),
    .hd_n      (hd_n),
    .quad_t2_n (quad_t2_n),
    .quad_hd_n (quad_hd_n),
    .latched   (is_latched),
    .count     (finger_cnt)
);

// File: tb/sim_pse_class_flags.sv
`timescale 1ns/1ps
module sim_pse_class_flags;
    localparam int DLY  = 20;
    localparam int MAXF = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cls_win = 0, mark_win = 0, port_lo = 0, iso_off = 0, ss_done = 0;
    logic sense_a = 0, sense_b = 0, wa_en = 0;
    logic t2_n, hd_n, quad_t2_n, quad_hd_n;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pse_class_flags #(.DELAY_CYC(DLY), .MAX_FINGERS(MAXF)) u0 (
        .clk(clk), .rst_n(rst_n), .cls_win(cls_win), .mark_win(mark_win),
        .port_lo(port_lo), .iso_off(iso_off), .ss_done(ss_done),
        .sense_a(sense_a), .sense_b(sense_b), .wa_en(wa_en),
        .t2_n(t2_n), .hd_n(hd_n), .quad_t2_n(quad_t2_n), .quad_hd_n(quad_hd_n)
    );

    // Expected asserted set {quad_hd, quad_t2, hd, t2} from the requirements.
    function automatic logic [3:0] exp_flags(int n, bit sa, bit sb);
        int c = (n > MAXF) ? MAXF : n;
        case (c)
            2: return (sa && sb) ? 4'b0101 : 4'b0001;
            3: return (sa && sb) ? 4'b0111 : 4'b0011;
            4: return 4'b0111;
            6: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(string req, logic [3:0] exp);
        logic [3:0] act = ~{quad_hd_n, quad_t2_n, hd_n, t2_n};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
        checks++;
        if ((act[1] && !act[0]) || (act[2] && !act[0]) || (act[3] && act[2:0] != 3'b111)) begin
            errors++;
            $display("FAIL R10: actual %b expected lower flags set", act);
        end
    endtask

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic finger();
        cls_win = 1; step(2); cls_win = 0; step(1);
        mark_win = 1; step(2); mark_win = 0; step(1);
    endtask

    task automatic fingers(int n);
        for (int i = 0; i < n; i++) finger();
    endtask

    task automatic clear_port();
        port_lo = 1; step(1); port_lo = 0; step(1);
    endtask

    task automatic drop_iso(string req);
        iso_off = 1; step(1); iso_off = 0;
        chk(req, 4'b0000);
        step(1);
    endtask

    // ss_done sampled at edge E0; released after E(DLY-1), asserted after E(DLY).
    task automatic power_up(bit sa, bit sb, logic [3:0] expv, string req);
        sense_a = sa; sense_b = sb;
        ss_done = 1; step(1); ss_done = 0;
        step(DLY - 1);
        chk("R5 settle", 4'b0000);
        step(1);
        chk(req, expv);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        step(2); rst_n = 1; step(1);
        chk("R11 reset", 4'b0000);

        // R3 decode table, pair sense low, plus R2 saturation
        for (int n = 0; n <= 8; n++) begin
            clear_port(); fingers(n);
            power_up(0, 0, exp_flags(n, 0, 0), (n >= 7) ? "R2 sat" : "R3 table");
            drop_iso("R7 release");
        end
        clear_port(); fingers(10);
        power_up(0, 0, 4'b0000, "R2 ten fingers");
        drop_iso("R7 release");

        // R4 pair sense
        clear_port(); fingers(2); power_up(1, 1, 4'b0101, "R4 two both"); drop_iso("R7");
        clear_port(); fingers(3); power_up(1, 1, 4'b0111, "R4 three both"); drop_iso("R7");
        clear_port(); fingers(2); power_up(1, 0, 4'b0001, "R4 two single"); drop_iso("R7");
        clear_port(); fingers(3); power_up(0, 1, 4'b0011, "R4 three single"); drop_iso("R7");

        // R1 lone mark windows ignored; events outside CLASSIFY ignored
        clear_port();
        finger();
        mark_win = 1; step(2); mark_win = 0; step(1);
        mark_win = 1; step(2); mark_win = 0; step(1);
        cls_win = 1; step(1); cls_win = 0; step(1);
        finger();
        power_up(0, 0, 4'b0001, "R1 lone marks");
        fingers(2);
        // R6 sense changes frozen
        sense_a = 1; sense_b = 1; step(3);
        chk("R6 frozen", 4'b0001);
        drop_iso("R7 release");
        power_up(0, 0, 4'b0001, "R1 R7 count kept");

        // R8 port_lo release and clear
        port_lo = 1; step(1); port_lo = 0;
        chk("R8 release", 4'b0000);
        step(1);
        power_up(0, 0, 4'b0000, "R8 cleared");

        // R9 wall adapter in CLASSIFY and LATCHED
        drop_iso("R7");
        wa_en = 1; #1; chk("R9 classify", 4'b1111); step(1);
        wa_en = 0; #1; chk("R9 drop", 4'b0000); step(1);

        // Random mix
        for (int it = 0; it < 25; it++) begin
            int n = $urandom_range(0, 9);
            bit sa = 1'($urandom_range(0, 1));
            bit sb = 1'($urandom_range(0, 1));
            logic [3:0] e = exp_flags(n, sa, sb);
            clear_port(); fingers(n);
            power_up(sa, sb, e, "R3 R4 random");
            sense_a = ~sa; sense_b = ~sb; step(2);
            chk("R6 random", e);
            if ($urandom_range(0, 1) == 1) begin
                wa_en = 1; #1; chk("R9 latched", 4'b1111);
                step(1); wa_en = 0; #1; chk("R9 restore", e);
                step(1);
            end
            drop_iso("R7 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule